// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block drives the open-drain clock and data lines of an I2C master through the two sequences that close a byte. The acknowledge sequence returns an ACK or a NACK bit after a byte has been received. The stop sequence ends a transfer with a stop condition. Software starts a sequence with a one-cycle go request, and the block clears the matching enable by itself when the sequence is over. Every phase is timed by a reloadable baud countdown. That countdown starts again only after the line the block has just changed is read back at its new level, so a slave that stretches the clock lengthens the cycle instead of shortening the next phase.

A sequence ends by setting a sticky interrupt flag. The stop sequence also sets a stop-seen status bit. A write to the data buffer while a sequence is running is refused and sets a sticky write-collision flag. Outputs `scl_oe` and `sda_oe` mean "pull the line low". Inputs `scl_in` and `sda_in` are the line levels, already synchronous to `clk`.

The state machine has ten states. ST_IDLE moves to ST_ACK_LOW on an acknowledge request, or to ST_STP_SDA on a stop request. The acknowledge path is ST_ACK_LOW, then ST_ACK_REL (leave on clock seen high), then ST_ACK_HIGH, then back to ST_IDLE (on expiry). The stop path is ST_STP_SDA (leave on data seen low), then ST_STP_LOW (leave on expiry), then ST_STP_REL (leave on clock seen high), then ST_STP_HIGH (leave on expiry), then ST_STP_SDAREL (leave on both lines seen high), then ST_STP_TAIL, then back to ST_IDLE (on expiry). ST_ACK_LOW, ST_ACK_HIGH, ST_STP_LOW, ST_STP_HIGH and ST_STP_TAIL each reload the countdown on entry and run for one baud period.

Top module: `i2c_endseq`

## Requirements
- R1: After reset both lines are released (`scl_oe`=0, `sda_oe`=0). `ack_en`, `stop_en`, `irq_flag`, `stop_seen` and `wcol` are 0, and `buf_q` is 0.
- R2: A baud period is E+1 clocks, where E is `baud_reload`. An acknowledge request pulls SCL low for E+1 clocks plus any time a slave holds the line. During the whole sequence, SDA is pulled low when `ack_bit`=0 (ACK) and released when `ack_bit`=1 (NACK). The value of `ack_bit` is taken in the cycle of the request.
- R3: After the block releases SCL, the high-phase count does not start until SCL is read high. The clock high time is therefore E+2 clocks measured from the line's rise (one sampling clock plus one period), whether or not a slave stretched the low phase.
- R4: At the end of an acknowledge, `ack_en` clears, `irq_flag` sets and SCL is pulled low. SCL then stays pulled low while the block is idle, until a stop sequence completes.
- R5: A stop request pulls SDA low and holds SCL low. After SDA is read low, one baud period is counted and SCL is then released. The line rises E+2 clocks after `stop_en` rises, plus any slave hold.
- R6: SDA is released E+2 clocks after SCL rises. `stop_seen` sets one clock after SDA is seen high while SCL is high.
- R7: E+1 clocks after `stop_seen` rises, `stop_en` clears and `irq_flag` sets. Both lines are then left released.
- R8: A `baud_reload` of 0 behaves as 1, giving a 2-clock period.
- R9: A `buf_wr` while a sequence runs sets `wcol` and leaves `buf_q` unchanged. While idle, `buf_wr` loads `buf_wdata` into `buf_q` and leaves `wcol` as it was.
- R10: `irq_flag` and `wcol` stay set until the matching clear input (`irq_clr`, `wcol_clr`) is pulsed.
- R11: If both go requests come in the same cycle, the acknowledge runs and the stop request is dropped. A go request made while a sequence is active is ignored, and its enable never rises.
- R12: `stop_seen` clears when either sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| baud_reload | input | 7 | baud countdown reload value E |
| ack_go | input | 1 | request an acknowledge sequence |
| ack_bit | input | 1 | bit to send, 0 = ACK, 1 = NACK |
| stop_go | input | 1 | request a stop sequence |
| buf_wr | input | 1 | data buffer write strobe |
| buf_wdata | input | 8 | data buffer write value |
| buf_q | output | 8 | data buffer contents |
| irq_clr | input | 1 | clear the interrupt flag |
| wcol_clr | input | 1 | clear the write-collision flag |
| scl_in | input | 1 | sampled SCL line level |
| sda_in | input | 1 | sampled SDA line level |
| scl_oe | output | 1 | pull SCL low |
| sda_oe | output | 1 | pull SDA low |
| ack_en | output | 1 | acknowledge sequence active |
| stop_en | output | 1 | stop sequence active |
| irq_flag | output | 1 | sequence-done interrupt flag |
| stop_seen | output | 1 | stop condition observed |
| wcol | output | 1 | write-collision flag |

## Verification
The bench builds the block with its default widths: a 7-bit reload and an 8-bit buffer. It drives reload values of 0, 1, 2, 3, 4, 5 and 9, which keep each sequence to a few dozen clocks. This makes it possible to measure every phase length exactly, to cover the zero-reload floor, and to add slave clock stretching of several cycles to both sequence types. Because the sequences are short, collision writes and competing go requests can be placed inside a running sequence at known cycles.

// File: rtl/i2c_endseq_pkg.sv
package i2c_endseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK_LOW,
        ST_ACK_REL,
        ST_ACK_HIGH,
        ST_STP_SDA,
        ST_STP_LOW,
        ST_STP_REL,
        ST_STP_HIGH,
        ST_STP_SDAREL,
        ST_STP_TAIL
    } seq_state_t;

    function automatic logic is_ack_state(input seq_state_t s);
        return (s == ST_ACK_LOW) || (s == ST_ACK_REL) || (s == ST_ACK_HIGH);
    endfunction

    function automatic logic is_counting(input seq_state_t s);
        return (s == ST_ACK_LOW) || (s == ST_ACK_HIGH) || (s == ST_STP_LOW) ||
               (s == ST_STP_HIGH) || (s == ST_STP_TAIL);
    endfunction

endpackage

// File: rtl/i2c_endseq_baud.sv
module i2c_endseq_baud #(
    parameter int BAUD_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] reload,
    input  logic              load,
    input  logic              run,
    output logic              expired
);

    localparam logic [BAUD_W-1:0] MIN_RELOAD = BAUD_W'(1);

    logic [BAUD_W-1:0] cnt;
    logic [BAUD_W-1:0] eff_reload;

    // a zero reload would give a one-clock period; floor it
    always_comb begin
        eff_reload = (reload == '0) ? MIN_RELOAD : reload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= eff_reload;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - BAUD_W'(1);
        end
    end

    always_comb begin
        expired = run && !load && (cnt == '0);
    end

endmodule

// File: rtl/i2c_endseq_fsm.sv
module i2c_endseq_fsm
    import i2c_endseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_go,
    input  logic       ack_bit,
    input  logic       stop_go,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       expired,
    output seq_state_t state,
    output logic       cnt_load,
    output logic       cnt_run,
    output logic       seq_start,
    output logic       seq_done,
    output logic       seen_set,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       ack_en,
    output logic       stop_en
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       ack_dat_q;
    logic       park_q;
    logic       ack_done;
    logic       stop_done;

    // next state and strobes
    always_comb begin
        state_d   = state_q;
        cnt_load  = 1'b0;
        seq_start = 1'b0;
        ack_done  = 1'b0;
        stop_done = 1'b0;
        seen_set  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_go) begin
                    state_d   = ST_ACK_LOW;
                    cnt_load  = 1'b1;
                    seq_start = 1'b1;
                end else if (stop_go) begin
                    state_d   = ST_STP_SDA;
                    seq_start = 1'b1;
                end
            end
            ST_ACK_LOW: begin
                if (expired) state_d = ST_ACK_REL;
            end
            ST_ACK_REL: begin
                if (scl_in) begin
                    state_d  = ST_ACK_HIGH;
                    cnt_load = 1'b1;
                end
            end
            ST_ACK_HIGH: begin
                if (expired) begin
                    state_d  = ST_IDLE;
                    ack_done = 1'b1;
                end
            end
            ST_STP_SDA: begin
                if (!sda_in) begin
                    state_d  = ST_STP_LOW;
                    cnt_load = 1'b1;
                end
            end
            ST_STP_LOW: begin
                if (expired) state_d = ST_STP_REL;
            end
            ST_STP_REL: begin
                if (scl_in) begin
                    state_d  = ST_STP_HIGH;
                    cnt_load = 1'b1;
                end
            end
            ST_STP_HIGH: begin
                if (expired) state_d = ST_STP_SDAREL;
            end
            ST_STP_SDAREL: begin
                if (sda_in && scl_in) begin
                    state_d  = ST_STP_TAIL;
                    cnt_load = 1'b1;
                    seen_set = 1'b1;
                end
            end
            ST_STP_TAIL: begin
                if (expired) begin
                    state_d   = ST_IDLE;
                    stop_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register with the latched ack bit and the idle clock park
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ack_dat_q <= 1'b1;
            park_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && ack_go) ack_dat_q <= ack_bit;
            if (ack_done)       park_q <= 1'b1;
            else if (stop_done) park_q <= 1'b0;
        end
    end

    // line drive and status per state
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:       scl_oe = park_q;
            ST_ACK_LOW: begin
                scl_oe = 1'b1;
                sda_oe = !ack_dat_q;
            end
            ST_ACK_REL,
            ST_ACK_HIGH:   sda_oe = !ack_dat_q;
            ST_STP_SDA,
            ST_STP_LOW: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_STP_REL,
            ST_STP_HIGH:   sda_oe = 1'b1;
            ST_STP_SDAREL,
            ST_STP_TAIL: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
        ack_en   = is_ack_state(state_q);
        stop_en  = (state_q != ST_IDLE) && !is_ack_state(state_q);
        cnt_run  = is_counting(state_q);
        seq_done = ack_done || stop_done;
        state    = state_q;
    end

endmodule

// File: rtl/i2c_endseq_flags.sv
module i2c_endseq_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              seq_start,
    input  logic              seq_done,
    input  logic              seen_set,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    output logic [DATA_W-1:0] buf_q,
    output logic              irq_flag,
    output logic              stop_seen,
    output logic              wcol
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q     <= '0;
            irq_flag  <= 1'b0;
            stop_seen <= 1'b0;
            wcol      <= 1'b0;
        end else begin
            if (buf_wr && !busy) buf_q <= buf_wdata;

            if (buf_wr && busy)  wcol <= 1'b1;
            else if (wcol_clr)   wcol <= 1'b0;

            if (seq_done)        irq_flag <= 1'b1;
            else if (irq_clr)    irq_flag <= 1'b0;

            if (seq_start)       stop_seen <= 1'b0;
            else if (seen_set)   stop_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_endseq.sv
module i2c_endseq
    import i2c_endseq_pkg::*;
#(
    parameter int BAUD_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              ack_go,
    input  logic              ack_bit,
    input  logic              stop_go,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic [DATA_W-1:0] buf_q,
    input  logic              irq_clr,
    input  logic              wcol_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              ack_en,
    output logic              stop_en,
    output logic              irq_flag,
    output logic              stop_seen,
    output logic              wcol
);

    seq_state_t state;
    logic       cnt_load;
    logic       cnt_run;
    logic       expired;
    logic       seq_start;
    logic       seq_done;
    logic       seen_set;
    logic       busy;

    i2c_endseq_baud #(.BAUD_W(BAUD_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (baud_reload),
        .load    (cnt_load),
        .run     (cnt_run),
        .expired (expired)
    );

    i2c_endseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_go    (ack_go),
        .ack_bit   (ack_bit),
        .stop_go   (stop_go),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .expired   (expired),
        .state     (state),
        .cnt_load  (cnt_load),
        .cnt_run   (cnt_run),
        .seq_start (seq_start),
        .seq_done  (seq_done),
        .seen_set  (seen_set),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .ack_en    (ack_en),
        .stop_en   (stop_en)
    );

    always_comb busy = (state != ST_IDLE);

    i2c_endseq_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .seq_start (seq_start),
        .seq_done  (seq_done),
        .seen_set  (seen_set),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .irq_clr   (irq_clr),
        .wcol_clr  (wcol_clr),
        .buf_q     (buf_q),
        .irq_flag  (irq_flag),
        .stop_seen (stop_seen),
        .wcol      (wcol)
    );

endmodule

// File: rtl/i2c_endseq_chk.sv
module i2c_endseq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_go,
    input logic              ack_bit,
    input logic              stop_go,
    input logic              buf_wr,
    input logic [DATA_W-1:0] buf_q,
    input logic              scl_in,
    input logic              sda_in,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              ack_en,
    input logic              stop_en,
    input logic              irq_flag,
    input logic              irq_clr,
    input logic              stop_seen,
    input logic              wcol
);

    p_ack_sda_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_en) |-> (sda_oe != $past(ack_bit)));

    p_ack_stretch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && !scl_oe && !scl_in) |=> ack_en);

    p_ack_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_en) |-> (irq_flag && scl_oe));

    p_stop_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_en && !scl_oe && !scl_in) |=> (stop_en && !stop_seen));

    p_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> (stop_en && $past(sda_in) && $past(scl_in)));

    p_stop_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_en) |-> (irq_flag && stop_seen && !scl_oe && !sda_oe));

    p_wcol_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && (ack_en || stop_en)) |=> (wcol && $stable(buf_q)));

    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_en && stop_en));

    p_go_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && stop_go && !ack_go) |=> !stop_en);

endmodule

bind i2c_endseq i2c_endseq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_go    (ack_go),
    .ack_bit   (ack_bit),
    .stop_go   (stop_go),
    .buf_wr    (buf_wr),
    .buf_q     (buf_q),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .ack_en    (ack_en),
    .stop_en   (stop_en),
    .irq_flag  (irq_flag),
    .irq_clr   (irq_clr),
    .stop_seen (stop_seen),
    .wcol      (wcol)
);

// File: tb/i2c_endseq_bench.sv
module i2c_endseq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] baud_reload = 7'd1;
    logic       ack_go = 1'b0;
    logic       ack_bit = 1'b0;
    logic       stop_go = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic [7:0] buf_q;
    logic       irq_clr = 1'b0;
    logic       wcol_clr = 1'b0;
    logic       scl_oe, sda_oe, ack_en, stop_en, irq_flag, stop_seen, wcol;
    logic       slave_low = 1'b0;
    logic       scl_line, sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    typedef struct {
        int kind;
        int v0;
        int v1;
        int v2;
        int v3;
    } exp_t;
    exp_t exp_q[$];

    assign scl_line = !(scl_oe || slave_low);
    assign sda_line = !sda_oe;

    always #2 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_endseq u_i2c_endseq (
        .clk(clk), .rst_n(rst_n), .baud_reload(baud_reload),
        .ack_go(ack_go), .ack_bit(ack_bit), .stop_go(stop_go),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
        .irq_clr(irq_clr), .wcol_clr(wcol_clr),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .ack_en(ack_en), .stop_en(stop_en),
        .irq_flag(irq_flag), .stop_seen(stop_seen), .wcol(wcol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: measures phase lengths, compares at each interrupt rise
    int t_start = 0, t_sclr = 0, t_sdar = 0, t_seen = 0;
    int cur_kind = 0;
    bit sda_at_rise = 1'b0;
    bit p_ack = 0, p_stop = 0, p_scl = 1, p_sda = 1, p_seen = 0, p_irq = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_en && !p_ack)     begin cur_kind = 0; t_start = cyc; end
            if (stop_en && !p_stop)   begin cur_kind = 1; t_start = cyc; end
            if (scl_line && !p_scl)   begin t_sclr = cyc; sda_at_rise = sda_line; end
            if (sda_line && !p_sda)   t_sdar = cyc;
            if (stop_seen && !p_seen) t_seen = cyc;
            if (irq_flag && !p_irq) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected interrupt", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cur_kind == e.kind, "R11 sequence kind", cur_kind, e.kind);
                    if (e.kind == 0) begin
                        chk(t_sclr - t_start == e.v0, "R2 ack SCL low time", t_sclr - t_start, e.v0);
                        chk(cyc - t_sclr == e.v1, "R3 ack SCL high time", cyc - t_sclr, e.v1);
                        chk(int'(sda_at_rise) == e.v2, "R2 ack SDA bit", int'(sda_at_rise), e.v2);
                    end else begin
                        chk(t_sclr - t_start == e.v0, "R5 stop SCL release", t_sclr - t_start, e.v0);
                        chk(t_sdar - t_sclr == e.v1, "R6 stop SDA release", t_sdar - t_sclr, e.v1);
                        chk(t_seen - t_sdar == e.v2, "R6 stop_seen delay", t_seen - t_sdar, e.v2);
                        chk(cyc - t_seen == e.v3, "R7 stop end delay", cyc - t_seen, e.v3);
                    end
                end
            end
            p_ack = ack_en; p_stop = stop_en; p_scl = scl_line;
            p_sda = sda_line; p_seen = stop_seen; p_irq = irq_flag;
        end
    end

    // driver: kind 0 = acknowledge, 1 = stop
    task automatic run_seq(input int kind, input int rl, input bit abit,
                           input int s, input bit poke, input bit both);
        exp_t e;
        int   eff;
        logic [7:0] pre;
        eff = (rl == 0) ? 1 : rl;
        if (kind == 0) begin
            e.kind = 0; e.v0 = eff + 1 + s; e.v1 = eff + 2; e.v2 = int'(abit); e.v3 = 0;
        end else begin
            e.kind = 1; e.v0 = eff + 2 + s; e.v1 = eff + 2; e.v2 = 1; e.v3 = eff + 1;
        end
        exp_q.push_back(e);
        baud_reload = 7'(rl);
        ack_bit = abit;
        slave_low = (s > 0);
        @(negedge clk);
        if (kind == 0 || both) ack_go = 1'b1;
        if (kind == 1 || both) stop_go = 1'b1;
        @(negedge clk);
        ack_go = 1'b0;
        stop_go = 1'b0;
        chk(kind == 0 ? (ack_en && !stop_en) : (stop_en && !ack_en),
            "R11 enable of requested sequence", {ack_en, stop_en}, kind == 0 ? 2 : 1);
        chk(!stop_seen, "R12 stop_seen cleared at start", stop_seen, 0);
        if (poke) begin
            pre = buf_q;
            buf_wdata = ~pre;
            buf_wr = 1'b1;
            if (kind == 0) stop_go = 1'b1; else ack_go = 1'b1;
            @(negedge clk);
            buf_wr = 1'b0;
            stop_go = 1'b0;
            ack_go = 1'b0;
            chk(wcol, "R9 wcol on busy write", wcol, 1);
            chk(buf_q == pre, "R9 buffer unchanged", buf_q, pre);
        end
        while (scl_oe) @(negedge clk);
        if (s > 0) begin
            repeat (s) @(posedge clk);
            #1 slave_low = 1'b0;
        end
        while (!irq_flag) @(negedge clk);
        chk(!ack_en && !stop_en, "R4 R7 enable self-cleared", {ack_en, stop_en}, 0);
        @(negedge clk);
        chk(irq_flag, "R10 irq sticky", irq_flag, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(!irq_flag, "R10 irq cleared", irq_flag, 0);
        repeat (3) @(negedge clk);
        chk(!ack_en && !stop_en && !irq_flag, "R11 ignored go left no sequence",
            {ack_en, stop_en, irq_flag}, 0);
        if (kind == 0) begin
            chk(!scl_line, "R4 SCL parked low", scl_line, 0);
        end else begin
            chk(scl_line && sda_line, "R7 lines released", {scl_line, sda_line}, 3);
            chk(stop_seen, "R6 stop_seen held", stop_seen, 1);
        end
        if (poke) begin
            chk(wcol, "R10 wcol sticky", wcol, 1);
            wcol_clr = 1'b1;
            @(negedge clk);
            wcol_clr = 1'b0;
            chk(!wcol, "R10 wcol cleared", wcol, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(!ack_en && !stop_en, "R1 enables", {ack_en, stop_en}, 0);
        chk(!irq_flag && !stop_seen && !wcol, "R1 flags", {irq_flag, stop_seen, wcol}, 0);
        chk(buf_q == 8'h00, "R1 buffer", buf_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        buf_wdata = 8'h3C;
        buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        chk(buf_q == 8'h3C, "R9 idle write stored", buf_q, 8'h3C);
        chk(!wcol, "R9 no wcol when idle", wcol, 0);

        run_seq(0, 3, 1'b0, 0, 1'b1, 1'b0);
        run_seq(0, 0, 1'b1, 0, 1'b0, 1'b0);   // R8
        run_seq(1, 2, 1'b0, 0, 1'b0, 1'b0);
        run_seq(0, 5, 1'b0, 3, 1'b0, 1'b0);   // R3 stretch
        run_seq(1, 4, 1'b0, 2, 1'b1, 1'b0);
        run_seq(0, 1, 1'b1, 0, 1'b0, 1'b1);   // R11 both requests
        run_seq(1, 9, 1'b0, 0, 1'b0, 1'b0);
        run_seq(1, 0, 1'b0, 1, 1'b0, 1'b0);   // R8 stop floor

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all sequences completed", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule